// File: doc/BRIEF.md
# Video Mode Descriptor Parser

This block reads a display-mode descriptor arriving as a stream of 32-bit words under a valid/ready handshake and turns it into timing-controller settings. The first word selects one of two list layouts (0 for the basic layout, 1 for the extended layout). The second word is a base mode number, presented on its own output. A run of timing-parameter words follows, closed by an all-ones terminator. Each timing-parameter word is forwarded on a write port. In the extended layout, a second run of tagged extension words follows, closed by another all-ones terminator. These words carry a pixel rate in kHz and sync polarities.

When a pixel-rate extension is present, it takes precedence over the two clock-divider bits of any control word in the main run. A control word is one whose top byte is 0xE0. Because the extensions arrive after the main run, the parser keeps the most recent control word. When the final terminator is accepted, it writes that word out again with its divider field forced to the undivided setting, so that an external clock selector alone sets the rate. A malformed list raises an error flag, and every word up to the next terminator is discarded. Every list ends with a one-cycle completion pulse.

Top module: `vmode_desc_parser`

## Requirements
- R1: The reset state is `s_ready`=0 during reset and 1 from the first clock after reset, `prm_valid`=0, `list_done`=0, `list_err`=0, `pix_rate_khz`=24000, and both sync polarity outputs 0 (positive).
- R2: Each accepted main-run word other than 0xFFFFFFFF appears unchanged on `prm_data`, with `prm_valid` high for exactly the cycle after it is accepted. The base mode word appears on `base_mode` and is not forwarded.
- R3: In layout 0, `list_done` is high for exactly the one cycle after the main-run terminator is accepted. A control word (top byte 0xE0) is forwarded with its divider bits 1:0 unchanged.
- R4: In layout 1, the main-run terminator does not pulse `list_done`. An extension word with top byte 0x00 sets `pix_rate_khz` to its bits 23:0 in the cycle after acceptance.
- R5: An extension word with top byte 0x01 sets `hsync_neg` from its bit 0 and `vsync_neg` from its bit 1 (1 means negative sync).
- R6: In layout 1, if a pixel-rate extension was accepted and the main run held a control word, then in the cycle after the final terminator the last control word is written again on the parameter port with bits 1:0 = 11, together with the `list_done` pulse.
- R7: In layout 1 without a pixel-rate extension, the final terminator writes nothing on the parameter port, and the rate stays at 24000.
- R8: A later extension of the same kind replaces an earlier one within a list.
- R9: A type word other than 0 or 1 sets `list_err` in the next cycle. All words up to and including the next 0xFFFFFFFF are discarded, and `list_done` pulses after that terminator.
- R10: An extension word whose top byte is neither 0x00 nor 0x01 sets `list_err`. Later words up to the terminator are discarded and change neither the rate nor the polarity.
- R11: A polarity extension with any of bits 23:2 set raises `list_err` and leaves the polarity outputs unchanged.
- R12: Accepting a type word returns the rate to 24000 and both polarities to positive. A type word of 0 or 1 also clears `list_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Descriptor word valid |
| s_data | input | 32 | Descriptor word |
| s_ready | output | 1 | Parser can take a word |
| prm_valid | output | 1 | Timing-parameter write strobe |
| prm_data | output | 32 | Timing-parameter word |
| base_mode | output | 32 | Base mode number of the current list |
| pix_rate_khz | output | 24 | Selected pixel rate in kHz |
| hsync_neg | output | 1 | Horizontal sync is negative |
| vsync_neg | output | 1 | Vertical sync is negative |
| list_done | output | 1 | One-cycle pulse when a list ends |
| list_err | output | 1 | Malformed list seen |

## Verification
The hardest case to reach from the ports is the late override. A control word sits in the main run, and the pixel rate that overrides it arrives only in the extension run, possibly more than once. The only visible effect is a second write, coinciding with the completion pulse. The stimulus therefore sweeps every divider value against zero, one and two rate extensions and against repeated polarity words, with all expected values worked out arithmetically. Errors in the middle of an extension run are reached by loading a rate first, then sending every illegal tag value and every single reserved polarity bit, followed by a legal-looking polarity word that must be ignored.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  typedef enum logic [2:0] {
    ST_TYPE,
    ST_BASE,
    ST_MAIN,
    ST_EXT,
    ST_DRAIN
  } vm_state_e;

  // Classification of one incoming word
  typedef struct packed {
    logic term;      // all-ones list terminator
    logic fmt0;      // type word value 0
    logic fmt1;      // type word value 1
    logic ctl;       // control-register word
    logic tag_rate;  // extension tag: pixel rate
    logic tag_pol;   // extension tag: polarity
    logic tag_bad;   // extension tag: unknown
    logic pol_rsvd;  // reserved polarity bits nonzero
  } vm_class_t;

endpackage

// File: rtl/vmode_word_decode.sv
module vmode_word_decode
  import vmode_pkg::*;
#(
  parameter int                 DATA_W  = 32,
  parameter int                 TAG_W   = 8,
  parameter int                 RATE_W  = 24,
  parameter logic [TAG_W-1:0]   CTL_TAG = 8'hE0
) (
  input  logic [DATA_W-1:0] word,
  output vm_class_t         cls
);

  localparam int POL_W = 2;

  logic [TAG_W-1:0] tag;
  assign tag = word[DATA_W-1 -: TAG_W];

  always_comb begin
    cls          = '0;
    cls.term     = &word;
    cls.fmt0     = (word == '0);
    cls.fmt1     = (word == DATA_W'(1));
    cls.ctl      = (tag == CTL_TAG);
    cls.tag_rate = (tag == '0);
    cls.tag_pol  = (tag == TAG_W'(1));
    cls.tag_bad  = !((tag == '0) || (tag == TAG_W'(1)));
    cls.pol_rsvd = |word[RATE_W-1:POL_W];
  end

endmodule

// File: rtl/vmode_ext_regs.sv
module vmode_ext_regs #(
  parameter int RATE_W   = 24,
  parameter int DEF_RATE = 24000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rate_ld,
  input  logic              pol_ld,
  input  logic [RATE_W-1:0] rate_in,
  input  logic [1:0]        pol_in,
  output logic [RATE_W-1:0] rate_q,
  output logic              rate_seen,
  output logic              hneg,
  output logic              vneg
);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      rate_q    <= RATE_W'(DEF_RATE);
      rate_seen <= 1'b0;
      hneg      <= 1'b0;
      vneg      <= 1'b0;
    end else begin
      if (rate_ld) begin
        rate_q    <= rate_in;
        rate_seen <= 1'b1;
      end
      if (pol_ld) begin
        hneg <= pol_in[0];
        vneg <= pol_in[1];
      end
    end
  end

  // R8
  rate_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_ld && !start) |=> (rate_q == $past(rate_in)) && rate_seen);

endmodule

// File: rtl/vmode_ctl_hold.sv
module vmode_ctl_hold #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic              seen,
  output logic [DATA_W-1:0] ovr_word
);

  logic [DATA_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      held <= '0;
      seen <= 1'b0;
    end else if (cap) begin
      held <= din;
      seen <= 1'b1;
    end
  end

  // Divider field forced to the undivided setting
  assign ovr_word = {held[DATA_W-1:DIV_W], {DIV_W{1'b1}}};

endmodule

// File: rtl/vmode_desc_parser.sv
module vmode_desc_parser
  import vmode_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RATE_W   = 24,
  parameter int DEF_RATE = 24000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              prm_valid,
  output logic [DATA_W-1:0] prm_data,
  output logic [DATA_W-1:0] base_mode,
  output logic [RATE_W-1:0] pix_rate_khz,
  output logic              hsync_neg,
  output logic              vsync_neg,
  output logic              list_done,
  output logic              list_err
);

  localparam int TAG_W = DATA_W - RATE_W;

  vm_state_e         st;
  vm_class_t         cls;
  logic              fmt_ext;
  logic              acc;
  logic              start, rate_ld, pol_ld, cap;
  logic              rate_seen, ctl_seen;
  logic [DATA_W-1:0] ovr_word;

  assign acc     = s_valid && s_ready;
  assign start   = acc && (st == ST_TYPE);
  assign rate_ld = acc && (st == ST_EXT) && !cls.term && cls.tag_rate;
  assign pol_ld  = acc && (st == ST_EXT) && !cls.term && cls.tag_pol && !cls.pol_rsvd;
  assign cap     = acc && (st == ST_MAIN) && !cls.term && cls.ctl;

  vmode_word_decode #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .RATE_W (RATE_W),
    .CTL_TAG(TAG_W'(8'hE0))
  ) u_dec (
    .word(s_data),
    .cls (cls)
  );

  vmode_ext_regs #(
    .RATE_W  (RATE_W),
    .DEF_RATE(DEF_RATE)
  ) u_ext (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rate_ld  (rate_ld),
    .pol_ld   (pol_ld),
    .rate_in  (s_data[RATE_W-1:0]),
    .pol_in   (s_data[1:0]),
    .rate_q   (pix_rate_khz),
    .rate_seen(rate_seen),
    .hneg     (hsync_neg),
    .vneg     (vsync_neg)
  );

  vmode_ctl_hold #(
    .DATA_W(DATA_W),
    .DIV_W (2)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cap     (cap),
    .din     (s_data),
    .seen    (ctl_seen),
    .ovr_word(ovr_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_TYPE;
      fmt_ext   <= 1'b0;
      s_ready   <= 1'b0;
      prm_valid <= 1'b0;
      prm_data  <= '0;
      base_mode <= '0;
      list_done <= 1'b0;
      list_err  <= 1'b0;
    end else begin
      s_ready   <= 1'b1;
      prm_valid <= 1'b0;
      list_done <= 1'b0;
      if (acc) begin
        case (st)
          ST_TYPE: begin
            if (cls.fmt0 || cls.fmt1) begin
              fmt_ext  <= cls.fmt1;
              list_err <= 1'b0;
              st       <= ST_BASE;
            end else begin
              list_err <= 1'b1;
              st       <= ST_DRAIN;
            end
          end
          ST_BASE: begin
            base_mode <= s_data;
            st        <= ST_MAIN;
          end
          ST_MAIN: begin
            if (cls.term) begin
              if (fmt_ext) begin
                st <= ST_EXT;
              end else begin
                list_done <= 1'b1;
                st        <= ST_TYPE;
              end
            end else begin
              prm_valid <= 1'b1;
              prm_data  <= s_data;
            end
          end
          ST_EXT: begin
            if (cls.term) begin
              list_done <= 1'b1;
              st        <= ST_TYPE;
              if (rate_seen && ctl_seen) begin
                prm_valid <= 1'b1;
                prm_data  <= ovr_word;
              end
            end else if (cls.tag_bad || (cls.tag_pol && cls.pol_rsvd)) begin
              list_err <= 1'b1;
              st       <= ST_DRAIN;
            end
          end
          default: begin
            if (cls.term) begin
              list_done <= 1'b1;
              st        <= ST_TYPE;
            end
          end
        endcase
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    list_done |=> !list_done);

  // R6
  ovr_div_chk: assert property (@(posedge clk) disable iff (rst)
    (prm_valid && list_done) |-> (prm_data[1:0] == 2'b11));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(list_err) |-> $past(acc));

  // R9
  bad_type_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !cls.fmt0 && !cls.fmt1) |=> list_err);

  // R10
  drain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && st == ST_DRAIN) |=> !prm_valid);

  // R12
  type_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (pix_rate_khz == RATE_W'(DEF_RATE)) && !hsync_neg && !vsync_neg);

endmodule

// File: tb/vmode_desc_parser_bench.sv
module vmode_desc_parser_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TERM = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        prm_valid;
  logic [31:0] prm_data;
  logic [31:0] base_mode;
  logic [23:0] pix_rate_khz;
  logic        hsync_neg, vsync_neg, list_done, list_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmode_desc_parser u_vmode_desc_parser (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .prm_valid(prm_valid), .prm_data(prm_data), .base_mode(base_mode),
    .pix_rate_khz(pix_rate_khz), .hsync_neg(hsync_neg), .vsync_neg(vsync_neg),
    .list_done(list_done), .list_err(list_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one word; return just after the edge that accepts it
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] main_word(input int k);
    return {8'h20 + 8'(k), 24'(k * 4099 + 7)};
  endfunction

  task automatic run_good(input int fmt, input int nmain, input bit use_ctl,
                          input logic [1:0] div, input int nrate, input logic [23:0] rate,
                          input int npol, input logic [1:0] pol);
    logic [31:0] ctlw;
    logic [1:0]  cur_pol;
    ctlw = 32'hE000_0C00 | {30'd0, div};
    send(32'(fmt));
    chk("R12 err cleared", {31'd0, list_err}, 0);
    chk("R12 rate default", {8'd0, pix_rate_khz}, 24000);
    chk("R12 pol default", {30'd0, vsync_neg, hsync_neg}, 0);
    send(32'h0000_0100 + 32'(nmain));
    chk("R2 base mode", base_mode, 32'h0000_0100 + 32'(nmain));
    chk("R2 base not forwarded", {31'd0, prm_valid}, 0);
    for (int k = 0; k < nmain; k++) begin
      logic [31:0] w;
      w = (use_ctl && k == 1) ? ctlw : main_word(k);
      send(w);
      chk("R2 forward valid", {31'd0, prm_valid}, 1);
      chk((use_ctl && k == 1) ? "R3 ctl unchanged" : "R2 forward data", prm_data, w);
    end
    send(TERM);
    if (fmt == 0) begin
      chk("R3 done pulse", {31'd0, list_done}, 1);
      chk("R3 no write", {31'd0, prm_valid}, 0);
      chk("R3 rate default", {8'd0, pix_rate_khz}, 24000);
      idle();
      chk("R3 done one cycle", {31'd0, list_done}, 0);
      return;
    end
    chk("R4 no done at main end", {31'd0, list_done}, 0);
    for (int r = 0; r < nrate; r++) begin
      logic [23:0] v;
      v = (r == nrate - 1) ? rate : rate + 24'd333;
      send({8'h00, v});
      chk(r == 0 ? "R4 rate load" : "R8 rate replace", {8'd0, pix_rate_khz}, {8'd0, v});
    end
    for (int p = 0; p < npol; p++) begin
      cur_pol = (p == npol - 1) ? pol : ~pol;
      send({8'h01, 22'd0, cur_pol});
      chk(p == 0 ? "R5 hsync" : "R8 pol replace hsync", {31'd0, hsync_neg}, {31'd0, cur_pol[0]});
      chk(p == 0 ? "R5 vsync" : "R8 pol replace vsync", {31'd0, vsync_neg}, {31'd0, cur_pol[1]});
    end
    send(TERM);
    chk("R6 done at final term", {31'd0, list_done}, 1);
    if (nrate > 0 && use_ctl && nmain > 1) begin
      chk("R6 override write", {31'd0, prm_valid}, 1);
      chk("R6 override data", prm_data, ctlw | 32'h3);
    end else begin
      chk("R7 no override write", {31'd0, prm_valid}, 0);
    end
    chk("R7 final rate", {8'd0, pix_rate_khz}, nrate > 0 ? {8'd0, rate} : 32'd24000);
    chk("R5 final pol", {30'd0, vsync_neg, hsync_neg}, npol > 0 ? {30'd0, pol} : 32'd0);
    chk("R12 no error", {31'd0, list_err}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready low in reset", {31'd0, s_ready}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 ready", {31'd0, s_ready}, 1);
    chk("R1 prm_valid", {31'd0, prm_valid}, 0);
    chk("R1 done", {31'd0, list_done}, 0);
    chk("R1 err", {31'd0, list_err}, 0);
    chk("R1 rate", {8'd0, pix_rate_khz}, 24000);
    chk("R1 pol", {30'd0, vsync_neg, hsync_neg}, 0);

    // Layout 0 sweep
    for (int d = 0; d < 4; d++)
      for (int n = 1; n < 5; n++)
        run_good(0, n, 1'b1, 2'(d), 0, 24'd0, 0, 2'd0);

    // Layout 1 sweep over divider, rate count and polarity count
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 4; d++)
        for (int nr = 0; nr < 3; nr++)
          for (int np = 0; np < 3; np++)
            run_good(1, 3, c[0], 2'(d), nr, 24'(8000 + d * 4000 + nr * 1111),
                     np, 2'(d) ^ 2'(np));

    // Bad type words
    for (int i = 0; i < 22; i++) begin
      logic [31:0] t;
      t = (i < 10) ? 32'(i + 2) : (i == 21 ? 32'hFFFF_0000 : (32'h1 << (i + 11)));
      send(t);
      chk("R9 bad type err", {31'd0, list_err}, 1);
      for (int k = 0; k < 3; k++) begin
        send(main_word(k));
        chk("R9 discarded", {31'd0, prm_valid}, 0);
        chk("R9 no early done", {31'd0, list_done}, 0);
      end
      send(TERM);
      chk("R9 done after drain", {31'd0, list_done}, 1);
      chk("R9 err held", {31'd0, list_err}, 1);
      run_good(0, 1, 1'b0, 2'd0, 0, 24'd0, 0, 2'd0);
    end

    // Unknown extension tags after a rate was loaded
    for (int tg = 2; tg < 256; tg++) begin
      send(32'd1);
      send(32'h55);
      send(32'hE000_0001);
      send(TERM);
      send({8'h00, 24'd12000});
      send({8'(tg), 24'h000123});
      chk("R10 bad tag err", {31'd0, list_err}, 1);
      chk("R10 rate kept", {8'd0, pix_rate_khz}, 12000);
      send({8'h01, 24'h000003});
      chk("R10 pol ignored", {30'd0, vsync_neg, hsync_neg}, 0);
      send({8'h00, 24'd5000});
      chk("R10 rate ignored", {8'd0, pix_rate_khz}, 12000);
      chk("R10 no write", {31'd0, prm_valid}, 0);
      send(TERM);
      chk("R10 done", {31'd0, list_done}, 1);
      chk("R10 no override write", {31'd0, prm_valid}, 0);
    end

    // Reserved polarity bits, one at a time
    for (int b = 2; b < 24; b++) begin
      send(32'd1);
      send(32'h77);
      send(TERM);
      send({8'h01, 24'h000002});
      send({8'h01, 24'(1) << b | 24'h3});
      chk("R11 rsvd err", {31'd0, list_err}, 1);
      chk("R11 pol unchanged", {30'd0, vsync_neg, hsync_neg}, 2);
      send(TERM);
      chk("R11 done", {31'd0, list_done}, 1);
    end
    run_good(1, 2, 1'b1, 2'd1, 1, 24'd36000, 1, 2'd3);

    idle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule